// File: doc/BRIEF.md
# Workgroup ring slot calculator

This block turns a three-dimensional workgroup coordinate into a position inside a power-of-two ring of entries that a producer stage shares with a consumer stage. It first flattens the coordinate into a linear workgroup number using the grid width and height. It then adds that number to a running ring pointer that was captured at dispatch. From the sum it derives four results:

- the slot index, taken from the low bits of the sum;
- the expected phase bit for the slot, which flips on every lap of the ring;
- a byte offset into a fixed-stride draw ring of 16-byte entries;
- a byte offset into a payload ring whose entry size is a parameter.

The ring pointer starts at the ring depth rather than at zero, so the first lap reports phase 1. In consumer mode the workgroup number is not added. Every consumer workgroup of a dispatch then lands on the slot that the base pointer names. Results are registered and reported with a valid strobe one cycle after the request.

Top module: `ring_slot_calc`

## Requirements
- R1: In producer mode (consumer_mode = 0), slot equals (base_ptr + x + y*grid_x + z*grid_x*grid_y) AND (DEPTH - 1).
- R2: The pointer sum and the linear index products wrap modulo 2^32.
- R3: In producer mode, phase equals bit log2(DEPTH) of the 32-bit pointer sum. It is 1 on odd laps and 0 on even laps.
- R4: In consumer mode (consumer_mode = 1), slot equals base_ptr AND (DEPTH - 1), and the workgroup coordinate and grid size have no effect on any output.
- R5: In consumer mode, phase equals bit log2(DEPTH) of base_ptr.
- R6: draw_off equals slot * 16.
- R7: payload_off equals slot * PAYLOAD_BYTES (default 64).
- R8: out_valid is low in reset and rises exactly one cycle after each cycle with in_valid high; it is low one cycle after a cycle with in_valid low.
- R9: While in_valid is low, slot, phase, draw_off and payload_off keep their last values.
- R10: cfg_error is 1 exactly when DEPTH is not a nonzero power of two; it is 0 for the default DEPTH of 16.
- R11: With base_ptr equal to DEPTH, the workgroup at coordinate (0,0,0) gets slot 0 and phase 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request strobe |
| consumer_mode | input | 1 | 1 = consumer mapping, 0 = producer mapping |
| wg_x | input | COORD_W | Workgroup X coordinate |
| wg_y | input | COORD_W | Workgroup Y coordinate |
| wg_z | input | COORD_W | Workgroup Z coordinate |
| grid_x | input | COORD_W | Grid width in workgroups |
| grid_y | input | COORD_W | Grid height in workgroups |
| base_ptr | input | PTR_W | Ring pointer captured at dispatch |
| out_valid | output | 1 | Result strobe |
| slot | output | log2(DEPTH) | Ring slot index |
| phase | output | 1 | Expected phase bit for the slot |
| draw_off | output | PTR_W | Byte offset into the draw ring |
| payload_off | output | PTR_W | Byte offset into the payload ring |
| cfg_error | output | 1 | Depth parameter is not a power of two |

## Verification
The assertions assume that rst_n holds for at least one clock edge, and that every input is steady around the rising edge of any cycle in which in_valid is high. They make no assumption on grid sizes: a coordinate outside the grid is a legal input and simply wraps. The stimulus changes inputs only on falling edges. It mixes hand-picked cases with unconstrained full-range values, so that the wrap, odd and even laps and both modes are reached without any constraint on the inputs.

// File: rtl/rslot_pkg.sv
package rslot_pkg;

  typedef enum logic {
    MAP_PRODUCER = 1'b0,
    MAP_CONSUMER = 1'b1
  } map_mode_e;

  function automatic bit is_pow2(input int unsigned v);
    return (v != 0) && ((v & (v - 1)) == 0);
  endfunction

endpackage

// File: rtl/rslot_linear.sv
module rslot_linear #(
  parameter int unsigned COORD_W = 16,
  parameter int unsigned PTR_W   = 32
) (
  input  logic [COORD_W-1:0] wg_x,
  input  logic [COORD_W-1:0] wg_y,
  input  logic [COORD_W-1:0] wg_z,
  input  logic [COORD_W-1:0] grid_x,
  input  logic [COORD_W-1:0] grid_y,
  output logic [PTR_W-1:0]   lin_idx
);
  logic [PTR_W-1:0] xe, ye, ze, gxe, gye;
  logic [PTR_W-1:0] row_term, plane_sz, plane_term;

  always_comb begin
    xe         = PTR_W'(wg_x);
    ye         = PTR_W'(wg_y);
    ze         = PTR_W'(wg_z);
    gxe        = PTR_W'(grid_x);
    gye        = PTR_W'(grid_y);
    row_term   = ye * gxe;
    plane_sz   = gxe * gye;
    plane_term = ze * plane_sz;
    lin_idx    = xe + row_term + plane_term;
  end
endmodule

// File: rtl/rslot_map.sv
module rslot_map #(
  parameter int unsigned PTR_W         = 32,
  parameter int unsigned DEPTH         = 16,
  parameter int unsigned DRAW_BYTES    = 16,
  parameter int unsigned PAYLOAD_BYTES = 64,
  localparam int unsigned IDX_W        = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  rslot_pkg::map_mode_e mode,
  input  logic [PTR_W-1:0]     base_ptr,
  input  logic [PTR_W-1:0]     lin_idx,
  output logic [IDX_W-1:0]     slot,
  output logic                 phase,
  output logic [PTR_W-1:0]     draw_off,
  output logic [PTR_W-1:0]     payload_off
);
  logic [PTR_W-1:0] ring_ptr;

  always_comb begin
    if (mode == rslot_pkg::MAP_CONSUMER) ring_ptr = base_ptr;
    else                                 ring_ptr = base_ptr + lin_idx;
  end

  generate
    if (DEPTH > 1) begin : g_multi
      assign slot  = ring_ptr[IDX_W-1:0];
      assign phase = ring_ptr[IDX_W];
    end else begin : g_single
      assign slot  = '0;
      assign phase = ring_ptr[0];
    end
  endgenerate

  always_comb begin
    draw_off    = PTR_W'(slot) * PTR_W'(DRAW_BYTES);
    payload_off = PTR_W'(slot) * PTR_W'(PAYLOAD_BYTES);
  end
endmodule

// File: rtl/rslot_pipe.sv
module rslot_pipe #(
  parameter int unsigned PTR_W = 32,
  parameter int unsigned IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [IDX_W-1:0] slot_d,
  input  logic             phase_d,
  input  logic [PTR_W-1:0] draw_d,
  input  logic [PTR_W-1:0] pay_d,
  output logic             valid_q,
  output logic [IDX_W-1:0] slot_q,
  output logic             phase_q,
  output logic [PTR_W-1:0] draw_q,
  output logic [PTR_W-1:0] pay_q
);
  logic             valid_n;
  logic [IDX_W-1:0] slot_n;
  logic             phase_n;
  logic [PTR_W-1:0] draw_n, pay_n;

  always_comb begin
    valid_n = in_valid;
    slot_n  = slot_q;
    phase_n = phase_q;
    draw_n  = draw_q;
    pay_n   = pay_q;
    if (in_valid) begin
      slot_n  = slot_d;
      phase_n = phase_d;
      draw_n  = draw_d;
      pay_n   = pay_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      slot_q  <= '0;
      phase_q <= 1'b0;
      draw_q  <= '0;
      pay_q   <= '0;
    end else begin
      valid_q <= valid_n;
      slot_q  <= slot_n;
      phase_q <= phase_n;
      draw_q  <= draw_n;
      pay_q   <= pay_n;
    end
  end
endmodule

// File: rtl/ring_slot_calc.sv
module ring_slot_calc #(
  parameter int unsigned COORD_W       = 16,
  parameter int unsigned PTR_W         = 32,
  parameter int unsigned DEPTH         = 16,
  parameter int unsigned DRAW_BYTES    = 16,
  parameter int unsigned PAYLOAD_BYTES = 64,
  localparam int unsigned IDX_W        = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic               consumer_mode,
  input  logic [COORD_W-1:0] wg_x,
  input  logic [COORD_W-1:0] wg_y,
  input  logic [COORD_W-1:0] wg_z,
  input  logic [COORD_W-1:0] grid_x,
  input  logic [COORD_W-1:0] grid_y,
  input  logic [PTR_W-1:0]   base_ptr,
  output logic               out_valid,
  output logic [IDX_W-1:0]   slot,
  output logic               phase,
  output logic [PTR_W-1:0]   draw_off,
  output logic [PTR_W-1:0]   payload_off,
  output logic               cfg_error
);
  localparam bit DEPTH_BAD = !rslot_pkg::is_pow2(DEPTH);

  logic [PTR_W-1:0]     lin_idx;
  logic [IDX_W-1:0]     slot_c;
  logic                 phase_c;
  logic [PTR_W-1:0]     draw_c, pay_c;
  rslot_pkg::map_mode_e mode;

  assign cfg_error = DEPTH_BAD;                                       // R10
  assign mode = consumer_mode ? rslot_pkg::MAP_CONSUMER : rslot_pkg::MAP_PRODUCER;

  rslot_linear #(.COORD_W(COORD_W), .PTR_W(PTR_W)) u_lin (
    .wg_x(wg_x), .wg_y(wg_y), .wg_z(wg_z),
    .grid_x(grid_x), .grid_y(grid_y), .lin_idx(lin_idx)
  );

  rslot_map #(.PTR_W(PTR_W), .DEPTH(DEPTH), .DRAW_BYTES(DRAW_BYTES),
              .PAYLOAD_BYTES(PAYLOAD_BYTES)) u_map (
    .mode(mode), .base_ptr(base_ptr), .lin_idx(lin_idx),
    .slot(slot_c), .phase(phase_c), .draw_off(draw_c), .payload_off(pay_c)
  );

  rslot_pipe #(.PTR_W(PTR_W), .IDX_W(IDX_W)) u_pipe (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .slot_d(slot_c), .phase_d(phase_c), .draw_d(draw_c), .pay_d(pay_c),
    .valid_q(out_valid), .slot_q(slot), .phase_q(phase),
    .draw_q(draw_off), .pay_q(payload_off)
  );

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);                                           // R8
  AST_VALID_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);                                         // R8
  AST_CONSUMER_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && consumer_mode) |=> (slot == $past(base_ptr[IDX_W-1:0])));  // R4
  AST_CONSUMER_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && consumer_mode && DEPTH > 1) |=> (phase == $past(base_ptr[IDX_W]))); // R5
  AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(slot) && $stable(phase) && $stable(draw_off) && $stable(payload_off))); // R9
endmodule

// File: tb/ring_slot_calc_tb.sv
module ring_slot_calc_tb;
  localparam int unsigned COORD_W = 16;
  localparam int unsigned PTR_W   = 32;
  localparam int unsigned DEPTH   = 16;
  localparam int unsigned LOG_D   = 4;
  localparam int unsigned PAY_B   = 64;

  typedef struct {
    logic [LOG_D-1:0] slot;
    logic             phase;
    logic [31:0]      draw;
    logic [31:0]      pay;
    logic             cons;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n;
  logic in_valid, consumer_mode;
  logic [COORD_W-1:0] wg_x, wg_y, wg_z, grid_x, grid_y;
  logic [PTR_W-1:0] base_ptr;
  logic out_valid, phase, cfg_error;
  logic [LOG_D-1:0] slot;
  logic [PTR_W-1:0] draw_off, payload_off;

  int checks = 0;
  int fails  = 0;
  exp_t q[$];
  exp_t last;
  bit have_last = 0;
  bit done = 0;

  always #2 clk = ~clk;

  ring_slot_calc #(.COORD_W(COORD_W), .PTR_W(PTR_W), .DEPTH(DEPTH),
                   .DRAW_BYTES(16), .PAYLOAD_BYTES(PAY_B)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .consumer_mode(consumer_mode),
    .wg_x(wg_x), .wg_y(wg_y), .wg_z(wg_z), .grid_x(grid_x), .grid_y(grid_y),
    .base_ptr(base_ptr), .out_valid(out_valid), .slot(slot), .phase(phase),
    .draw_off(draw_off), .payload_off(payload_off), .cfg_error(cfg_error)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(input bit cons, input int x, input int y, input int z,
                      input int gx, input int gy, input logic [31:0] base);
    exp_t e;
    logic [31:0] lin, ptr;
    @(negedge clk);
    in_valid = 1'b1; consumer_mode = cons;
    wg_x = x[COORD_W-1:0]; wg_y = y[COORD_W-1:0]; wg_z = z[COORD_W-1:0];
    grid_x = gx[COORD_W-1:0]; grid_y = gy[COORD_W-1:0]; base_ptr = base;
    lin = 32'(wg_x) + 32'(wg_y) * 32'(grid_x) + 32'(wg_z) * 32'(grid_x) * 32'(grid_y);
    ptr = cons ? base : base + lin;
    e.slot = ptr[LOG_D-1:0]; e.phase = ptr[LOG_D];
    e.draw = 32'(e.slot) * 32'd16; e.pay = 32'(e.slot) * 32'(PAY_B); e.cons = cons;
    q.push_back(e);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      consumer_mode = ~consumer_mode;
      wg_x = wg_x + 16'd7; grid_x = grid_x + 16'd3; base_ptr = base_ptr + 32'd5;
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    #1;
    if (rst_n && !done) begin
      if (out_valid) begin
        if (q.size() == 0) chk(0, "R8 unexpected out_valid", 1, 0);
        else begin
          exp_t e;
          e = q.pop_front();
          chk(slot == e.slot, e.cons ? "R4 consumer slot" : "R1/R2 producer slot", slot, e.slot);
          chk(phase == e.phase, e.cons ? "R5 consumer phase" : "R3 producer phase", phase, e.phase);
          chk(draw_off == e.draw, "R6 draw offset", draw_off, e.draw);
          chk(payload_off == e.pay, "R7 payload offset", payload_off, e.pay);
          last = e; have_last = 1;
        end
      end else begin
        chk(q.size() == 0, "R8 missing out_valid", 0, 1);
        if (have_last) begin
          chk(slot == last.slot && phase == last.phase, "R9 hold slot/phase", slot, last.slot);
          chk(draw_off == last.draw && payload_off == last.pay, "R9 hold offsets", draw_off, last.draw);
        end
      end
    end
  end

  initial begin
    #(4 * 100000);
    chk(0, "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; consumer_mode = 1'b0;
    wg_x = '0; wg_y = '0; wg_z = '0; grid_x = 16'd1; grid_y = 16'd1; base_ptr = '0;
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R8 reset out_valid", out_valid, 0);
    chk(slot == '0 && draw_off == '0 && payload_off == '0, "R8 reset results", slot, 0);
    chk(cfg_error == 1'b0, "R10 cfg_error", cfg_error, 0);
    rst_n = 1'b1;
    // R11: first lap from a pointer initialised to DEPTH
    send(0, 0, 0, 0, 4, 4, DEPTH);
    idle(1);
    // R1 R3: 3 + 2*5 + 1*5*4 = 33, 16 + 33 = 49 -> slot 1, phase 1
    send(0, 3, 2, 1, 5, 4, 32'd16);
    // R3 even lap: 32 + 5 = 37 -> slot 5 phase 0
    send(0, 5, 0, 0, 8, 8, 32'd32);
    // R2 wrap: FFFFFFFE + 5 = 3
    send(0, 5, 0, 0, 9, 9, 32'hFFFF_FFFE);
    // R2 product wrap
    send(0, 16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF, 32'h1234_5678);
    idle(3);
    // R4 R5: consumer ignores coordinates
    send(1, 100, 200, 300, 400, 500, 32'd29);
    send(1, 7, 0, 9, 1, 1, 32'd29);
    send(1, 0, 0, 0, 1, 1, 32'd47);
    idle(4);
    for (int i = 0; i < 60; i++) begin
      send(i[0] & i[2], $urandom, $urandom, $urandom, $urandom, $urandom, $urandom);
      if ((i % 5) == 4) idle(2);
    end
    idle(4);
    done = 1;
    chk(q.size() == 0, "R8 all results delivered", q.size(), 0);
    finish_run();
  end
endmodule